// File: doc/BRIEF.md
# Configurable Parallel Host Port

This block is the slave side of an 8-bit parallel port. Through it an external host writes one input word to the core and reads one output word from it. A 7-bit configuration word sets how the port behaves, and the core can change it while running. The configuration selects the bus style, the polarity of the data strobe, the transfer size, how the byte-select pin maps to the two byte lanes, the polarity of the two handshake flag pins, whether the two flags are merged onto one pin, and the sense of the empty flag in the core's status word.

In 8-bit mode, one access to the low lane is a complete transfer. In 16-bit mode, the host moves the low lane first and the high lane second, and the high-lane access completes the transfer. The host pins go through a two-flop synchronizer. Each access takes effect when its strobe is released. The core side is synchronous: it loads the output word, reads the input word at any time, and sees a 2-bit status.

Top module: `hport_top`

## Requirements
- R1: After reset, the configuration is all zero, the input-full flag is 0 and the output-empty flag is 1. So `pin_full`=0, `pin_empty`=1, `core_stat`=2'b10, `core_rdata`=0 and `hst_doe`=0.
- R2: Configuration bit 1 selects the bus style. When it is 0, `hst_a` low is a host write strobe and `hst_b` low is a host read strobe. When it is 1, `hst_b` is the single data strobe and `hst_a` gives the direction (1 = read, 0 = write). A configuration write masks strobe events for the next SETTLE cycles.
- R3: Configuration bit 2 applies only in single-strobe mode: 0 makes the data strobe active-low and 1 makes it active-high. In two-strobe mode it has no effect.
- R4: The byte lane used by an access equals `hst_bsel` XOR configuration bit 3. Lane 0 is bits 7:0 and lane 1 is bits 15:8 of the data words.
- R5: When configuration bit 0 is 0 (8-bit mode), a lane-0 access completes a transfer. A lane-1 access still moves its byte but leaves both flags unchanged.
- R6: When configuration bit 0 is 1 (16-bit mode), a lane-1 access completes a transfer. A lane-0 access moves its byte without touching the flags.
- R7: A completing host write sets input-full, and `core_rd` clears it. If both happen in the same cycle, the set wins.
- R8: `core_wr` loads the output word and clears output-empty, and a completing host read sets it. If both happen in the same cycle, the core write wins.
- R9: Configuration bit 4 sets the polarity of the flag pins: 0 makes them active-high and 1 makes them active-low.
- R10: When configuration bit 5 is 1, `pin_full` shows input-full OR output-empty, and `pin_empty` is unchanged.
- R11: `core_stat` bit 0 is input-full. Bit 1 is output-empty, inverted when configuration bit 6 is 1.
- R12: Data and lane are taken while the strobe is active, and the flags change only after the strobe is released.
- R13: `core_rdata` shows the input word written by the host. While a host read is active, `hst_doe` is 1 and `hst_dout` carries the selected lane of the output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 7 | New configuration word |
| core_wr | input | 1 | Core write of the output word |
| core_wdata | input | 16 | Output word from the core |
| core_rd | input | 1 | Core read of the input word, clears input-full |
| core_rdata | output | 16 | Input word written by the host |
| core_stat | output | 2 | Status: {empty as seen, full} |
| hst_a | input | 1 | Write strobe, or read/write direction line |
| hst_b | input | 1 | Read strobe, or single data strobe |
| hst_bsel | input | 1 | Byte-select pin |
| hst_din | input | 8 | Host write data |
| hst_dout | output | 8 | Host read data |
| hst_doe | output | 1 | Host data output enable |
| pin_full | output | 1 | Input-full flag pin |
| pin_empty | output | 1 | Output-empty flag pin |

## Verification
The assertions assume a well-behaved host. In two-strobe mode it never asserts the read and write strobes together. It holds data, byte-select and the direction line steady for the whole strobe. Each strobe level lasts well over two clocks, so the synchronizer sees every edge. The bench holds every strobe for five clocks and releases it for at least six. It changes data and byte-select one clock before a strobe begins. When it changes the configuration, it moves the pins to the idle level of the new configuration in the same cycle as the configuration write.

// File: rtl/hport_pkg.sv
package hport_pkg;

  // Configuration word, bit 6 down to bit 0.
  typedef struct packed {
    logic obe_inv;     // bit 6: status empty bit inverted
    logic merge;       // bit 5: full pin = full | empty
    logic flag_low;    // bit 4: flag pins active-low
    logic lane_swap;   // bit 3: byte-select lane inversion
    logic ds_high;     // bit 2: single data strobe active-high
    logic one_strobe;  // bit 1: direction line plus one data strobe
    logic wide;        // bit 0: 16-bit transfers
  } hport_cfg_t;

  localparam int CFG_BITS = $bits(hport_cfg_t);

  // Byte lane addressed by an access.
  function automatic logic lane_of(input logic bsel, input logic swap);
    return bsel ^ swap;
  endfunction

endpackage

// File: rtl/hport_sync.sv
module hport_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/hport_strobe.sv
module hport_strobe #(
  parameter int DW     = 8,
  parameter int SETTLE = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          one_strobe,
  input  logic          ds_high,
  input  logic          lane_swap,
  input  logic          a_s,
  input  logic          b_s,
  input  logic          bsel_s,
  input  logic [DW-1:0] dat_s,
  output logic          wr_evt,
  output logic          rd_evt,
  output logic          evt_lane,
  output logic [DW-1:0] evt_data,
  output logic          rd_on,
  output logic          lane_now
);

  localparam int SW = $clog2(SETTLE + 1);

  logic [SW-1:0] settle;
  logic          masked;
  logic          ds_on;
  logic          wr_now;
  logic          rd_now;
  logic          wr_q;
  logic          rd_q;

  assign masked   = (settle != '0);
  assign lane_now = hport_pkg::lane_of(bsel_s, lane_swap);

  always_comb begin
    ds_on = ds_high ? b_s : ~b_s;
    if (one_strobe) begin
      wr_now = ds_on & ~a_s;
      rd_now = ds_on &  a_s;
    end else begin
      wr_now = ~a_s;
      rd_now = ~b_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      settle   <= SW'(SETTLE);
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      evt_lane <= 1'b0;
      evt_data <= '0;
    end else begin
      if (cfg_we)
        settle <= SW'(SETTLE);
      else if (masked)
        settle <= settle - 1'b1;
      wr_q <= (masked || cfg_we) ? 1'b0 : wr_now;
      rd_q <= (masked || cfg_we) ? 1'b0 : rd_now;
      if (wr_now || rd_now)
        evt_lane <= lane_now;
      if (wr_now)
        evt_data <= dat_s;
    end
  end

  // trailing edge of an accepted strobe
  assign wr_evt = wr_q & ~wr_now & ~masked;
  assign rd_evt = rd_q & ~rd_now & ~masked;
  assign rd_on  = rd_q;

endmodule

// File: rtl/hport_regs.sv
module hport_regs #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wide,
  input  logic            wr_evt,
  input  logic            rd_evt,
  input  logic            evt_lane,
  input  logic [DW-1:0]   evt_data,
  input  logic            core_wr,
  input  logic [2*DW-1:0] core_wdata,
  input  logic            core_rd,
  output logic [2*DW-1:0] in_word,
  output logic [2*DW-1:0] out_word,
  output logic            ibf,
  output logic            obe,
  output logic            wr_final,
  output logic            rd_final
);

  localparam int LANES = 2;

  logic [DW-1:0] in_lane [LANES];

  assign wr_final = wr_evt & (evt_lane == wide);
  assign rd_final = rd_evt & (evt_lane == wide);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        in_lane[g] <= '0;
      else if (wr_evt && (evt_lane == 1'(g)))
        in_lane[g] <= evt_data;
    end
    assign in_word[g*DW +: DW] = in_lane[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word <= '0;
      ibf      <= 1'b0;
      obe      <= 1'b1;
    end else begin
      if (core_wr)
        out_word <= core_wdata;
      if (wr_final)
        ibf <= 1'b1;
      else if (core_rd)
        ibf <= 1'b0;
      if (core_wr)
        obe <= 1'b0;
      else if (rd_final)
        obe <= 1'b1;
    end
  end

endmodule

// File: rtl/hport_outs.sv
module hport_outs #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flag_low,
  input  logic            merge,
  input  logic            obe_inv,
  input  logic            ibf,
  input  logic            obe,
  input  logic [2*DW-1:0] in_word,
  input  logic [2*DW-1:0] out_word,
  input  logic            lane_now,
  input  logic            rd_on,
  output logic            pin_full,
  output logic            pin_empty,
  output logic [1:0]      stat,
  output logic [2*DW-1:0] rdata,
  output logic [DW-1:0]   dout,
  output logic            doe
);

  logic full_src;

  assign full_src = merge ? (ibf | obe) : ibf;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_full  <= 1'b0;
      pin_empty <= 1'b1;
      stat      <= 2'b10;
      rdata     <= '0;
      dout      <= '0;
      doe       <= 1'b0;
    end else begin
      pin_full  <= full_src ^ flag_low;
      pin_empty <= obe ^ flag_low;
      stat      <= {obe ^ obe_inv, ibf};
      rdata     <= in_word;
      dout      <= lane_now ? out_word[2*DW-1:DW] : out_word[DW-1:0];
      doe       <= rd_on;
    end
  end

endmodule

// File: rtl/hport_top.sv
module hport_top #(
  parameter int DW     = 8,
  parameter int SETTLE = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [hport_pkg::CFG_BITS-1:0]    cfg_wdata,
  input  logic                              core_wr,
  input  logic [2*DW-1:0]                   core_wdata,
  input  logic                              core_rd,
  output logic [2*DW-1:0]                   core_rdata,
  output logic [1:0]                        core_stat,
  input  logic                              hst_a,
  input  logic                              hst_b,
  input  logic                              hst_bsel,
  input  logic [DW-1:0]                     hst_din,
  output logic [DW-1:0]                     hst_dout,
  output logic                              hst_doe,
  output logic                              pin_full,
  output logic                              pin_empty
);

  import hport_pkg::*;

  localparam int WW = 2 * DW;

  hport_cfg_t      cfg_q;
  logic [1:0]      stb_s;
  logic [DW:0]     bus_s;
  logic            wr_evt;
  logic            rd_evt;
  logic            evt_lane;
  logic [DW-1:0]   evt_data;
  logic            rd_on;
  logic            lane_now;
  logic [WW-1:0]   in_word;
  logic [WW-1:0]   out_word;
  logic            ibf_q;
  logic            obe_q;
  logic            wr_final;
  logic            rd_final;

  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (cfg_we)
      cfg_q <= hport_cfg_t'(cfg_wdata);
  end

  hport_sync #(.W(2), .RST_VAL(2'b11)) i_sync_stb (
    .clk (clk),
    .rst (rst),
    .d   ({hst_a, hst_b}),
    .q   (stb_s)
  );

  hport_sync #(.W(DW + 1), .RST_VAL('0)) i_sync_bus (
    .clk (clk),
    .rst (rst),
    .d   ({hst_bsel, hst_din}),
    .q   (bus_s)
  );

  hport_strobe #(.DW(DW), .SETTLE(SETTLE)) i_strobe (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .one_strobe (cfg_q.one_strobe),
    .ds_high    (cfg_q.ds_high),
    .lane_swap  (cfg_q.lane_swap),
    .a_s        (stb_s[1]),
    .b_s        (stb_s[0]),
    .bsel_s     (bus_s[DW]),
    .dat_s      (bus_s[DW-1:0]),
    .wr_evt     (wr_evt),
    .rd_evt     (rd_evt),
    .evt_lane   (evt_lane),
    .evt_data   (evt_data),
    .rd_on      (rd_on),
    .lane_now   (lane_now)
  );

  hport_regs #(.DW(DW)) i_regs (
    .clk        (clk),
    .rst        (rst),
    .wide       (cfg_q.wide),
    .wr_evt     (wr_evt),
    .rd_evt     (rd_evt),
    .evt_lane   (evt_lane),
    .evt_data   (evt_data),
    .core_wr    (core_wr),
    .core_wdata (core_wdata),
    .core_rd    (core_rd),
    .in_word    (in_word),
    .out_word   (out_word),
    .ibf        (ibf_q),
    .obe        (obe_q),
    .wr_final   (wr_final),
    .rd_final   (rd_final)
  );

  hport_outs #(.DW(DW)) i_outs (
    .clk       (clk),
    .rst       (rst),
    .flag_low  (cfg_q.flag_low),
    .merge     (cfg_q.merge),
    .obe_inv   (cfg_q.obe_inv),
    .ibf       (ibf_q),
    .obe       (obe_q),
    .in_word   (in_word),
    .out_word  (out_word),
    .lane_now  (lane_now),
    .rd_on     (rd_on),
    .pin_full  (pin_full),
    .pin_empty (pin_empty),
    .stat      (core_stat),
    .rdata     (core_rdata),
    .dout      (hst_dout),
    .doe       (hst_doe)
  );

endmodule

// File: rtl/hport_chk.sv
module hport_chk (
  input logic clk,
  input logic rst,
  input logic core_wr,
  input logic core_rd,
  input logic ibf,
  input logic obe,
  input logic wr_evt,
  input logic rd_evt,
  input logic wr_final,
  input logic rd_final
);

  // R8
  obe_clear_chk: assert property (@(posedge clk) disable iff (rst)
    core_wr |=> !obe);

  // R8
  obe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(obe) |-> $past(rd_final));

  // R7
  ibf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ibf) |-> $past(wr_final));

  // R7
  ibf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (core_rd && !wr_final) |=> !ibf);

  // R12
  evt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_evt && rd_evt));

endmodule

bind hport_top hport_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .core_wr  (core_wr),
  .core_rd  (core_rd),
  .ibf      (ibf_q),
  .obe      (obe_q),
  .wr_evt   (wr_evt),
  .rd_evt   (rd_evt),
  .wr_final (wr_final),
  .rd_final (rd_final)
);

// File: tb/test_hport_top.sv
module test_hport_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_wdata = '0;
  logic        core_wr = 1'b0;
  logic [15:0] core_wdata = '0;
  logic        core_rd = 1'b0;
  logic [15:0] core_rdata;
  logic [1:0]  core_stat;
  logic        hst_a = 1'b1;
  logic        hst_b = 1'b1;
  logic        hst_bsel = 1'b0;
  logic [7:0]  hst_din = '0;
  logic [7:0]  hst_dout;
  logic        hst_doe;
  logic        pin_full;
  logic        pin_empty;

  int n_run  = 0;
  int n_fail = 0;

  logic [6:0]  cfg = '0;
  logic [15:0] exp_in = '0;
  logic [15:0] exp_out = '0;
  logic        exp_ibf = 1'b0;
  logic        exp_obe = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hport_top i_hport_top (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .core_wr    (core_wr),
    .core_wdata (core_wdata),
    .core_rd    (core_rd),
    .core_rdata (core_rdata),
    .core_stat  (core_stat),
    .hst_a      (hst_a),
    .hst_b      (hst_b),
    .hst_bsel   (hst_bsel),
    .hst_din    (hst_din),
    .hst_dout   (hst_dout),
    .hst_doe    (hst_doe),
    .pin_full   (pin_full),
    .pin_empty  (pin_empty)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s cfg=%h act=%h exp=%h", req, cfg, act, expv);
    end
  endtask

  task automatic check_state(input string req);
    logic e_full;
    e_full = (cfg[5] ? (exp_ibf | exp_obe) : exp_ibf) ^ cfg[4];
    check({req, " R9 R10 full pin"}, 32'(pin_full), 32'(e_full));
    check({req, " R9 empty pin"}, 32'(pin_empty), 32'(exp_obe ^ cfg[4]));
    check({req, " R11 status"}, 32'(core_stat), 32'({exp_obe ^ cfg[6], exp_ibf}));
    check({req, " R13 core data"}, 32'(core_rdata), 32'(exp_in));
  endtask

  task automatic idle_pins();
    hst_a = 1'b1;
    hst_b = cfg[1] ? ~cfg[2] : 1'b1;
  endtask

  task automatic set_cfg(input logic [6:0] v);
    @(negedge clk);
    cfg       = v;
    cfg_we    = 1'b1;
    cfg_wdata = v;
    idle_pins();
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic core_write(input logic [15:0] w);
    @(negedge clk);
    core_wr    = 1'b1;
    core_wdata = w;
    @(negedge clk);
    core_wr = 1'b0;
    repeat (2) @(negedge clk);
    exp_out = w;
    exp_obe = 1'b0;
    check_state("R8 core write");
  endtask

  task automatic core_read();
    @(negedge clk);
    core_rd = 1'b1;
    @(negedge clk);
    core_rd = 1'b0;
    repeat (2) @(negedge clk);
    exp_ibf = 1'b0;
    check_state("R7 core read");
  endtask

  // collide: 0 none, 1 core read at the event cycle, 2 core write at the event cycle
  task automatic host_op(input logic is_wr, input logic bsel, input logic [7:0] d,
                         input int collide, input logic [15:0] cw);
    logic lane;
    logic fin;
    lane = bsel ^ cfg[3];          // R4
    fin  = (lane == cfg[0]);       // R5 R6
    @(negedge clk);
    hst_bsel = bsel;
    hst_din  = d;
    @(negedge clk);
    if (cfg[1]) begin              // R2 R3
      hst_a = ~is_wr;
      hst_b = cfg[2];
    end else begin
      hst_a = ~is_wr;
      hst_b = is_wr;
    end
    repeat (5) @(negedge clk);
    check_state("R12 held strobe");
    if (!is_wr) begin
      check("R13 read enable", 32'(hst_doe), 32'd1);
      check("R4 R13 read lane", 32'(hst_dout), 32'(lane ? exp_out[15:8] : exp_out[7:0]));
    end
    idle_pins();
    @(negedge clk);
    @(negedge clk);
    if (collide == 1) core_rd = 1'b1;
    if (collide == 2) begin
      core_wr    = 1'b1;
      core_wdata = cw;
    end
    @(negedge clk);
    core_rd = 1'b0;
    core_wr = 1'b0;
    repeat (4) @(negedge clk);
    if (is_wr) begin
      if (lane) exp_in[15:8] = d;
      else exp_in[7:0] = d;
      if (fin) exp_ibf = 1'b1;     // R7 set wins over a same-cycle core read
    end else begin
      if (fin) exp_obe = 1'b1;
      if (collide == 2) begin      // R8 core write wins
        exp_out = cw;
        exp_obe = 1'b0;
      end
    end
    check_state(is_wr ? "R5 R6 host write" : "R5 R6 host read");
    check("R13 read enable off", 32'(hst_doe), 32'd0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1
    check_state("R1 reset");
    check("R1 read enable", 32'(hst_doe), 32'd0);

    // Sweep bus style, strobe polarity, lane swap and width.
    for (int c = 0; c < 16; c++) begin
      set_cfg(7'(c));
      for (int k = 0; k < 2; k++) begin
        logic ln;
        ln = (k == 0) ? ~cfg[0] : cfg[0];
        host_op(1'b1, ln ^ cfg[3], 8'(c * 16 + k * 7 + 3), 0, 16'h0);
      end
      core_read();
      core_write(16'(c * 4099 + 1));
      for (int k = 0; k < 2; k++) begin
        logic ln;
        ln = (k == 0) ? ~cfg[0] : cfg[0];
        host_op(1'b0, ln ^ cfg[3], 8'h0, 0, 16'h0);
      end
    end

    // Sweep flag polarity, merge and status sense over all flag states.
    for (int c = 0; c < 8; c++) begin
      set_cfg({3'(c), 4'b0000});
      core_write(16'(c * 257 + 5));
      host_op(1'b1, 1'b0, 8'(c + 8'h40), 0, 16'h0);
      host_op(1'b0, 1'b0, 8'h0, 0, 16'h0);
      core_read();
    end

    // Same-cycle collisions in both bus styles.
    for (int c = 0; c < 2; c++) begin
      set_cfg(c == 0 ? 7'b0000000 : 7'b0000110);
      host_op(1'b1, 1'b0, 8'(8'hA5 + c), 1, 16'h0);            // R7
      host_op(1'b0, 1'b0, 8'h0, 2, 16'(16'h3C00 + c));         // R8
      host_op(1'b0, 1'b0, 8'h0, 0, 16'h0);                     // R8 new word
      core_read();
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule